// File: doc/BRIEF.md
# UART Interrupt Identification and Transmit-Empty Unit

This block sits beside the receive and transmit FIFOs of a FIFO-capable UART. It takes the raw pending flags of the receiver (line error, data available at or above the trigger level, character timeout) and the transmit side, gates each with its enable bit, and drives a single interrupt line. It also presents the code of the highest-ranked pending source on a read-only identification byte. The unit owns the transmit-empty event itself. That event can fire at once or after a deliberate delay, depending on how full the transmit FIFO has been. A read of the identification byte or a write to the holding register clears it, and it fires at once when the FIFO mode bit is flipped.

The transmit-empty tracker is a four-state machine:
- `TXE_FILL`: the FIFO holds data.
- `TXE_WAIT`: the FIFO has just drained after never holding two bytes at once, and a delay of one frame minus the final stop bit is running.
- `TXE_SHOW`: the empty condition is indicated and the interrupt is pending.
- `TXE_SEEN`: empty is still indicated, but the interrupt has been acknowledged by an identification read.

The transitions are:
- **drain-fast**: `TXE_FILL`→`TXE_SHOW`.
- **drain-slow**: `TXE_FILL`→`TXE_WAIT`.
- **delay-done**: `TXE_WAIT`→`TXE_SHOW`.
- **ack**: `TXE_SHOW`→`TXE_SEEN`.
- **refill**: any state→`TXE_FILL`, on a holding write or a non-zero count.
- **mode-flip**: any state→`TXE_SHOW`, on a change of the FIFO enable.

The same tracker supplies the polled-mode status bits for "transmit FIFO empty" and "transmitter fully idle". These bits remain valid with every interrupt enable cleared.

Top module: `uart_irq_id`

## Requirements
- R1: Pending sources are ranked line error (code 4'h6), then character timeout (4'hC), then receive data available (4'h4), then transmit empty (4'h2). The identification byte's bits [3:0] show the highest one, and read 4'h1 when nothing is pending.
- R2: A source counts as pending only while its enable is set; receive data and timeout share one enable. `irq` is high exactly when some enabled source is pending, and it follows source and enable changes in the same cycle.
- R3: Identification bits [7:6] read 2'b11 while `fifo_en` is high and 2'b00 otherwise; bits [5:4] read zero.
- R4: When the transmit count reaches zero and the FIFO has held two or more bytes at once since the last empty event, the empty indication and the transmit interrupt appear in the next cycle.
- R5: Otherwise, draining starts a delay of `frame_bits`−1 `bit_tick` pulses. The empty indication appears in the cycle after the last of those pulses.
- R6: A holding-register write clears the transmit interrupt and the empty indication in the next cycle, and it abandons any running delay; a later drain starts a fresh delay.
- R7: An identification read clears the transmit interrupt only when code 4'h2 is the reported code. The empty status bit stays high.
- R8: Any change of `fifo_en` raises the empty indication and the transmit interrupt (if enabled) in the next cycle, even during a running delay.
- R9: `thre` reports the delayed empty indication. `temt` is high when `thre` is high and `tx_shift_busy` is low. Both work with all enables cleared (polled mode).
- R10: After reset, `thre` and `temt` are high, and with enables cleared the identification byte reads 8'h01 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | FIFO mode control bit |
| ien_line_stat | input | 1 | Enable for line error interrupt |
| ien_rx_data | input | 1 | Enable for receive data and timeout interrupts |
| ien_tx_empty | input | 1 | Enable for transmit empty interrupt |
| src_line_err | input | 1 | Receiver line error pending |
| src_rx_avail | input | 1 | Receive data at or above trigger level |
| src_rx_timeout | input | 1 | Receive character timeout pending |
| tx_count | input | CNT_W | Bytes in transmit FIFO |
| tx_shift_busy | input | 1 | Transmit shift register is sending |
| thr_wr | input | 1 | Strobe: write to holding register |
| iir_rd | input | 1 | Strobe: read of identification byte |
| bit_tick | input | 1 | One pulse per serial bit time |
| frame_bits | input | FRM_W | Bit times per frame including stop bits |
| irq | output | 1 | Interrupt request |
| iir | output | 8 | Identification byte |
| thre | output | 1 | Status: transmit FIFO empty (delayed) |
| temt | output | 1 | Status: FIFO and shift register both empty |

## Verification
The ranking is tried with all sources pending and then with them removed one at a time from the top, which separates each adjacent pair in the order. Enables are also toggled with a source held, to tell gating apart from ranking. The transmit side is driven with a single-byte fill and with a fill that reaches two bytes. The first must wait exactly `frame_bits`−1 ticks, one tick short being checked as still busy; the second must report at once, which tells the two drain paths apart. Identification reads are issued while a higher code is shown and while 4'h2 is shown, and the mode bit is flipped during a running delay. These patterns separate acknowledge, cancel and mode-flip handling from the normal delay path.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

    typedef enum logic [3:0] {
        ID_NONE = 4'h1,
        ID_TXE  = 4'h2,
        ID_RXD  = 4'h4,
        ID_LSR  = 4'h6,
        ID_TMO  = 4'hC
    } iid_code_e;

    typedef enum logic [1:0] {
        TXE_FILL,
        TXE_WAIT,
        TXE_SHOW,
        TXE_SEEN
    } txe_state_e;

    localparam int NSRC = 4;

    // request slot index -> code; higher index ranks higher
    function automatic iid_code_e code_of(input int idx);
        case (idx)
            3:       code_of = ID_LSR;
            2:       code_of = ID_TMO;
            1:       code_of = ID_RXD;
            default: code_of = ID_TXE;
        endcase
    endfunction

endpackage

// File: rtl/uart_iid_prio.sv
module uart_iid_prio
    import uart_iid_pkg::*;
(
    input  logic [NSRC-1:0] req,
    input  logic            fifo_on,
    output logic            irq,
    output iid_code_e       code,
    output logic [7:0]      iir
);

    always_comb begin
        code = ID_NONE;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i]) code = code_of(i);
        end
    end

    assign irq = |req;
    assign iir = {fifo_on, fifo_on, 2'b00, code};

endmodule

// File: rtl/uart_iid_txe.sv
module uart_iid_txe
    import uart_iid_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int FRM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             thr_wr,
    input  logic             rd_ack,
    input  logic             bit_tick,
    input  logic [FRM_W-1:0] frame_bits,
    output logic             tx_show,
    output logic             thre
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_TWO  = CNT_W'(2);
    localparam logic [FRM_W-1:0] FRM_ONE  = FRM_W'(1);

    txe_state_e       state, state_n;
    logic [FRM_W-1:0] wait_cnt, wait_cnt_n;
    logic             multi, multi_n;
    logic             fifo_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= TXE_SHOW;
            wait_cnt <= '0;
            multi    <= 1'b0;
            fifo_q   <= 1'b0;
        end else begin
            state    <= state_n;
            wait_cnt <= wait_cnt_n;
            multi    <= multi_n;
            fifo_q   <= fifo_en;
        end
    end

    // transitions
    always_comb begin
        state_n    = state;
        wait_cnt_n = wait_cnt;
        multi_n    = multi;
        if (fifo_en != fifo_q) begin
            state_n = TXE_SHOW;              // mode-flip
            multi_n = 1'b0;
        end else if (thr_wr) begin
            state_n = TXE_FILL;              // refill
            if (tx_count >= CNT_TWO) multi_n = 1'b1;
        end else begin
            unique case (state)
                TXE_FILL: begin
                    if (tx_count == CNT_ZERO) begin
                        multi_n = 1'b0;
                        if (multi) begin
                            state_n = TXE_SHOW;  // drain-fast
                        end else begin
                            state_n    = TXE_WAIT;  // drain-slow
                            wait_cnt_n = frame_bits - FRM_ONE;
                        end
                    end else if (tx_count >= CNT_TWO) begin
                        multi_n = 1'b1;
                    end
                end
                TXE_WAIT: begin
                    if (tx_count != CNT_ZERO) begin
                        state_n = TXE_FILL;
                    end else if (bit_tick) begin
                        if (wait_cnt <= FRM_ONE) state_n = TXE_SHOW;  // delay-done
                        else wait_cnt_n = wait_cnt - FRM_ONE;
                    end
                end
                TXE_SHOW: begin
                    if (tx_count != CNT_ZERO) state_n = TXE_FILL;
                    else if (rd_ack)          state_n = TXE_SEEN;  // ack
                end
                TXE_SEEN: begin
                    if (tx_count != CNT_ZERO) state_n = TXE_FILL;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        tx_show = (state == TXE_SHOW);
        thre    = (state == TXE_SHOW) || (state == TXE_SEEN);
    end

endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
    import uart_iid_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int FRM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             ien_line_stat,
    input  logic             ien_rx_data,
    input  logic             ien_tx_empty,
    input  logic             src_line_err,
    input  logic             src_rx_avail,
    input  logic             src_rx_timeout,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             tx_shift_busy,
    input  logic             thr_wr,
    input  logic             iir_rd,
    input  logic             bit_tick,
    input  logic [FRM_W-1:0] frame_bits,
    output logic             irq,
    output logic [7:0]       iir,
    output logic             thre,
    output logic             temt
);

    logic            tx_show;
    logic            rd_ack;
    logic [NSRC-1:0] req;
    iid_code_e       code;

    assign req = {src_line_err   & ien_line_stat,
                  src_rx_timeout & ien_rx_data,
                  src_rx_avail   & ien_rx_data,
                  tx_show        & ien_tx_empty};

    uart_iid_prio u_prio (
        .req     (req),
        .fifo_on (fifo_en),
        .irq     (irq),
        .code    (code),
        .iir     (iir)
    );

    assign rd_ack = iir_rd && (code == ID_TXE);

    uart_iid_txe #(
        .CNT_W (CNT_W),
        .FRM_W (FRM_W)
    ) u_txe (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .tx_count   (tx_count),
        .thr_wr     (thr_wr),
        .rd_ack     (rd_ack),
        .bit_tick   (bit_tick),
        .frame_bits (frame_bits),
        .tx_show    (tx_show),
        .thre       (thre)
    );

    assign temt = thre && !tx_shift_busy;

endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_en,
    input logic       ien_line_stat,
    input logic       ien_rx_data,
    input logic       ien_tx_empty,
    input logic       src_line_err,
    input logic       src_rx_timeout,
    input logic       thr_wr,
    input logic [7:0] iir,
    input logic       thre,
    input logic       temt
);

    logic fifo_prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fifo_prev <= 1'b0;
        else        fifo_prev <= fifo_en;
    end

    // R1
    line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_line_err && ien_line_stat) |-> (iir[3:0] == 4'h6));

    // R1
    tmo_over_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rx_timeout && ien_rx_data && !(src_line_err && ien_line_stat))
            |-> (iir[3:0] == 4'hC));

    // R3
    fifo_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iir[7:4] == {fifo_en, fifo_en, 2'b00});

    // R2
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !thre |-> (iir[3:0] != 4'h2));

    // R6
    wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && (fifo_en == fifo_prev)) |=> !thre);

    // R8
    mode_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en != fifo_prev) |=> thre);

    // R9
    temt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        temt |-> thre);

endmodule

bind uart_irq_id uart_irq_id_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fifo_en        (fifo_en),
    .ien_line_stat  (ien_line_stat),
    .ien_rx_data    (ien_rx_data),
    .ien_tx_empty   (ien_tx_empty),
    .src_line_err   (src_line_err),
    .src_rx_timeout (src_rx_timeout),
    .thr_wr         (thr_wr),
    .iir            (iir),
    .thre           (thre),
    .temt           (temt)
);

// File: tb/tb_uart_irq_id.sv
`timescale 1ns/100ps
module tb_uart_irq_id;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic       ien_line_stat = 1'b0, ien_rx_data = 1'b0, ien_tx_empty = 1'b0;
    logic       src_line_err = 1'b0, src_rx_avail = 1'b0, src_rx_timeout = 1'b0;
    logic [4:0] tx_count = '0;
    logic       tx_shift_busy = 1'b0;
    logic       thr_wr = 1'b0, iir_rd = 1'b0, bit_tick = 1'b0;
    logic [3:0] frame_bits = 4'd10;
    logic       irq, thre, temt;
    logic [7:0] iir;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_irq_id dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .ien_line_stat(ien_line_stat), .ien_rx_data(ien_rx_data),
        .ien_tx_empty(ien_tx_empty), .src_line_err(src_line_err),
        .src_rx_avail(src_rx_avail), .src_rx_timeout(src_rx_timeout),
        .tx_count(tx_count), .tx_shift_busy(tx_shift_busy),
        .thr_wr(thr_wr), .iir_rd(iir_rd), .bit_tick(bit_tick),
        .frame_bits(frame_bits), .irq(irq), .iir(iir),
        .thre(thre), .temt(temt)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic nclk();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            nclk(); bit_tick = 1'b1;
            nclk(); bit_tick = 1'b0;
        end
    endtask

    // one byte in, then drained: starts the delay
    task automatic one_byte();
        nclk(); thr_wr = 1'b1; tx_count = 5'd1;
        nclk(); thr_wr = 1'b0; tx_count = 5'd0;
        nclk();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) nclk();
        rst_n = 1'b1;
        nclk();
        chk("R10 iir", iir, 8'h01);
        chk("R10 irq", {7'd0, irq}, 8'h00);
        chk("R10 thre", {7'd0, thre}, 8'h01);
        chk("R10 temt", {7'd0, temt}, 8'h01);
        fifo_en = 1'b1;
        nclk();
    endtask

    task automatic t_prio();
        ien_line_stat = 1; ien_rx_data = 1; ien_tx_empty = 1;
        src_line_err = 1; src_rx_avail = 1; src_rx_timeout = 1;
        #1 chk("R1 all pending", iir, 8'hC6);
        chk("R2 irq on", {7'd0, irq}, 8'h01);
        src_line_err = 0;
        #1 chk("R1 timeout over rx", iir, 8'hCC);
        src_rx_timeout = 0;
        #1 chk("R1 rx over tx", iir, 8'hC4);
        src_rx_avail = 0;
        #1 chk("R1 tx only", iir, 8'hC2);
        ien_tx_empty = 0;
        #1 chk("R2 tx gated", iir, 8'hC1);
        chk("R2 irq off", {7'd0, irq}, 8'h00);
        ien_line_stat = 0; src_line_err = 1;
        #1 chk("R2 line gated", iir, 8'hC1);
        ien_line_stat = 1;
        #1 chk("R2 same-cycle enable", iir, 8'hC6);
        src_line_err = 0; ien_tx_empty = 1;
        #1 chk("R3 fifo bits", iir, 8'hC2);
    endtask

    task automatic t_rd_clear();
        nclk(); src_line_err = 1; iir_rd = 1;
        nclk(); iir_rd = 0; src_line_err = 0;
        #1 chk("R7 read under line code keeps tx", iir, 8'hC2);
        nclk(); iir_rd = 1;
        nclk(); iir_rd = 0;
        #1 chk("R7 read clears tx", iir, 8'hC1);
        chk("R7 thre stays", {7'd0, thre}, 8'h01);
    endtask

    task automatic t_delay();
        one_byte();
        chk("R5 delay started", {7'd0, thre}, 8'h00);
        ticks(8);
        chk("R5 one tick short", {7'd0, thre}, 8'h00);
        ticks(1);
        chk("R5 delay done thre", {7'd0, thre}, 8'h01);
        chk("R5 delay done iir", iir, 8'hC2);
    endtask

    task automatic t_cancel();
        one_byte();
        ticks(3);
        nclk(); thr_wr = 1'b1; tx_count = 5'd1;
        nclk(); thr_wr = 1'b0;
        chk("R6 write clears", {7'd0, thre}, 8'h00);
        ticks(12);
        chk("R6 no empty while filled", {7'd0, thre}, 8'h00);
        tx_count = 5'd0;
        nclk();
        ticks(8);
        chk("R6 fresh delay", {7'd0, thre}, 8'h00);
        ticks(1);
        chk("R6 fresh delay done", {7'd0, thre}, 8'h01);
    endtask

    task automatic t_immediate();
        nclk(); thr_wr = 1'b1; tx_count = 5'd1;
        nclk(); thr_wr = 1'b1; tx_count = 5'd2;
        nclk(); thr_wr = 1'b0;
        nclk(); tx_count = 5'd1;
        nclk(); tx_count = 5'd0;
        nclk();
        chk("R4 immediate thre", {7'd0, thre}, 8'h01);
        chk("R4 immediate iir", iir, 8'hC2);
        one_byte();
        chk("R4 history cleared", {7'd0, thre}, 8'h00);
        ticks(9);
        chk("R5 after history clear", {7'd0, thre}, 8'h01);
    endtask

    task automatic t_mode();
        one_byte();
        chk("R8 in delay", {7'd0, thre}, 8'h00);
        fifo_en = 1'b0;
        nclk();
        chk("R8 flip off thre", {7'd0, thre}, 8'h01);
        chk("R8 flip off iir", iir, 8'h02);
        fifo_en = 1'b1;
        nclk();
        chk("R8 flip on iir", iir, 8'hC2);
    endtask

    task automatic t_polled();
        ien_line_stat = 0; ien_rx_data = 0; ien_tx_empty = 0;
        #1 chk("R9 polled iir", iir, 8'hC1);
        chk("R9 polled thre", {7'd0, thre}, 8'h01);
        tx_shift_busy = 1'b1;
        #1 chk("R9 temt busy", {7'd0, temt}, 8'h00);
        tx_shift_busy = 1'b0;
        #1 chk("R9 temt idle", {7'd0, temt}, 8'h01);
        nclk(); thr_wr = 1'b1; tx_count = 5'd1;
        nclk(); thr_wr = 1'b0;
        chk("R9 polled filled temt", {7'd0, temt}, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        t_reset();
        t_prio();
        t_rd_clear();
        t_delay();
        t_cancel();
        t_immediate();
        t_mode();
        t_polled();
        repeat (2) nclk();
        finish_run();
    end

endmodule